// File: doc/BRIEF.md
# Bus Bridge Address Window Decoder

This block sits between two address buses and decides, for every incoming access, which of eight programmable windows claims it and what the address becomes on the far side. Software programs each window through a plain 32-bit register port. Each window holds a control word, a start address, a bound address (start plus length) and an offset. The control word carries an enable bit, an address-space code and four access qualifiers: program, data, supervisor and user.

For a lookup, the caller presents an address, a 3-bit space code and four qualifier bits. The block returns a hit flag, the index of the winning window and the translated address. The lookup is purely combinational. A register write changes the lookup result from the next clock edge onward.

Windows whose index is a multiple of four resolve addresses in 4 KiB steps. The other windows resolve in 64 KiB steps. A revision parameter below 2 leaves only the lower four windows in place.

Top module: `addr_window_decoder`

## Requirements
- R1: A synchronous reset clears every stored word. After reset, every register reads 0 and no lookup hits.
- R2: Register index 5*w+k addresses window w. Word k is 0 for control, 1 for start, 2 for bound and 3 for offset. Word 4 of each window, and every index of 40 or above, reads 0 and ignores writes. The control word keeps only bits 31 and 23:16, except bit 19; its other bits read 0.
- R3: A window whose control bit 31 is clear never hits.
- R4: Control bits 18:16 hold the space code: 0 is the 16-bit space, 1 the 24-bit space and 2 the 32-bit space. A window hits only when this code equals `in_space` and the code is at most 2. Code 3 or above never hits.
- R5: Control bits 23, 22, 21 and 20 (program, data, supervisor, user) must equal `in_qual[3:0]` in that order, bit for bit, for a window to hit.
- R6: Windows 0 and 4 ignore the low 12 bits of start, bound and offset. All other windows ignore the low 16 bits. Those low bits read back as 0. A window hits when start <= address < bound, compared unsigned.
- R7: On a hit, `out_addr` equals `in_addr` plus the window offset, modulo 2^32. On a miss, `hit` is 0, `hit_idx` is 0 and `out_addr` equals `in_addr`.
- R8: When several windows hit, the lowest index wins.
- R9: With `REV` below 2, windows 4 to 7 read as 0 and never hit.
- R10: A lookup follows its inputs with no clock. A register write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_addr | input | 32 | Address to decode |
| in_space | input | 3 | Space code of the access |
| in_qual | input | 4 | Qualifiers {program, data, supervisor, user} |
| hit | output | 1 | A window claims the access |
| hit_idx | output | 3 | Index of the winning window |
| out_addr | output | 32 | Translated address |

## Verification
A stored field that is corrupted shows up at once, in the same cycle, on `hit`, `hit_idx` or `out_addr` for any address near that window's edges. It also shows up one read later on `reg_rdata`, where the masked low bits expose any granularity error. A wrong priority order or a missing enable gate shows up only when windows overlap or a programmed window is switched off. The stimulus therefore places overlapping windows, a disabled window and an unknown space code side by side. It then probes the inclusive start and the exclusive bound of each window, and the address just outside each.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned AW = 32;
  // control bits that are stored: enable, qualifiers, space code
  localparam logic [AW-1:0] CTRL_KEEP = 32'h80F7_0000;

  function automatic logic [AW-1:0] gran_mask(input int unsigned idx);
    return (idx % 4 == 0) ? 32'hFFFF_F000 : 32'hFFFF_0000;
  endfunction

  function automatic logic in_range(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                    input logic [AW-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  function automatic logic [AW-1:0] xlate(input logic [AW-1:0] a, input logic [AW-1:0] ofs);
    return a + ofs;
  endfunction
endpackage

// File: rtl/awd_window.sv
module awd_window
  import awd_pkg::*;
#(
  parameter int unsigned IDX     = 0,
  parameter bit          PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    word,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  input  logic [AW-1:0] in_addr,
  input  logic [2:0]    in_space,
  input  logic [3:0]    in_qual,
  output logic          en,
  output logic          hit,
  output logic [AW-1:0] xaddr
);
  localparam logic [AW-1:0] GM = gran_mask(IDX);

  logic [AW-1:0] ctrl_q, start_q, bound_q, offs_q;

  generate
    if (PRESENT) begin : g_store
      always_ff @(posedge clk) begin
        if (rst) begin
          ctrl_q  <= '0;
          start_q <= '0;
          bound_q <= '0;
          offs_q  <= '0;
        end else if (we) begin
          case (word)
            3'd0: ctrl_q  <= wdata & CTRL_KEEP;
            3'd1: start_q <= wdata & GM;
            3'd2: bound_q <= wdata & GM;
            3'd3: offs_q  <= wdata & GM;
            default: ;
          endcase
        end
      end
    end else begin : g_absent
      assign ctrl_q  = '0;
      assign start_q = '0;
      assign bound_q = '0;
      assign offs_q  = '0;
    end
  endgenerate

  always_comb begin
    case (word)
      3'd0:    rdata = ctrl_q;
      3'd1:    rdata = start_q;
      3'd2:    rdata = bound_q;
      3'd3:    rdata = offs_q;
      default: rdata = '0;
    endcase
  end

  logic space_known, mode_eq, addr_in;
  assign space_known = (ctrl_q[18:16] <= 3'd2);
  assign mode_eq     = (ctrl_q[18:16] == in_space) && (ctrl_q[23:20] == in_qual);
  assign addr_in     = in_range(in_addr, start_q, bound_q);
  assign en          = ctrl_q[31];
  assign hit         = en && space_known && mode_eq && addr_in;
  assign xaddr       = xlate(in_addr, offs_q);
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int unsigned N    = 8,
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned REV  = 2,
  localparam int unsigned NACT   = (REV < 2) ? NWIN / 2 : NWIN,
  localparam int unsigned NREG   = NWIN * 5,
  localparam int unsigned REG_AW = $clog2(NREG),
  localparam int unsigned IW     = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       in_addr,
  input  logic [2:0]        in_space,
  input  logic [3:0]        in_qual,
  output logic              hit,
  output logic [IW-1:0]     hit_idx,
  output logic [31:0]       out_addr
);
  logic [REG_AW-1:0] sel_win, sel_word;
  logic              addr_ok;
  assign sel_win  = reg_addr / REG_AW'(5);
  assign sel_word = reg_addr % REG_AW'(5);
  assign addr_ok  = reg_addr < REG_AW'(NREG);

  logic [NWIN-1:0] win_hit, win_en;
  logic [31:0]     win_rd [NWIN];
  logic [31:0]     win_x  [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    awd_window #(.IDX(w), .PRESENT(w < NACT)) u_win (
      .clk(clk), .rst(rst),
      .we(reg_we && addr_ok && (sel_win == REG_AW'(w))),
      .word(sel_word[2:0]), .wdata(reg_wdata), .rdata(win_rd[w]),
      .in_addr(in_addr), .in_space(in_space), .in_qual(in_qual),
      .en(win_en[w]), .hit(win_hit[w]), .xaddr(win_x[w])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (addr_ok && sel_win == REG_AW'(w)) reg_rdata = win_rd[w];
    end
  end

  logic          any_hit;
  logic [IW-1:0] win_idx;
  awd_prio #(.N(NWIN)) u_prio (.req(win_hit), .any(any_hit), .idx(win_idx));

  assign hit      = any_hit;
  assign hit_idx  = any_hit ? win_idx : '0;
  assign out_addr = any_hit ? win_x[win_idx] : in_addr;

  // R1: right after reset nothing is enabled
  p_reset_quiet_r1: assert property (@(posedge clk) $fell(rst) |-> !hit);
  // R3: a claimed access always belongs to an enabled window
  p_hit_enabled_r3: assert property (@(posedge clk) disable iff (rst) hit |-> win_en[hit_idx]);
  // R4: unknown space codes never produce a hit
  p_space_known_r4: assert property (@(posedge clk) disable iff (rst) hit |-> in_space <= 3'd2);
  // R7: a miss passes the address through with index 0
  p_miss_pass_r7: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (out_addr == in_addr) && (hit_idx == '0));
  // R8: no lower-index window also hits
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
    hit |-> (win_hit & ((NWIN'(1) << hit_idx) - NWIN'(1))) == '0);
  // R9: absent windows never win
  p_rev_gate_r9: assert property (@(posedge clk) disable iff (rst)
    hit |-> (32'(hit_idx) < NACT));
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] in_addr = '0;
  logic [2:0]  in_space = '0;
  logic [3:0]  in_qual = '0;
  logic [31:0] reg_rdata, out_addr, rd1, out1;
  logic        hit, hit1;
  logic [2:0]  hit_idx, idx1;

  addr_window_decoder dut (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_addr(in_addr), .in_space(in_space),
    .in_qual(in_qual), .hit(hit), .hit_idx(hit_idx), .out_addr(out_addr));

  addr_window_decoder #(.REV(1)) dut_r1 (.clk(clk), .rst(rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd1), .in_addr(in_addr),
    .in_space(in_space), .in_qual(in_qual), .hit(hit1), .hit_idx(idx1), .out_addr(out1));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [2:0] s,
                      input logic [3:0] q, input logic eh, input logic [2:0] ei,
                      input logic [31:0] eo);
    in_addr = a; in_space = s; in_qual = q;
    #1;
    check({tag, " hit"}, 32'(hit), 32'(eh));
    check({tag, " idx"}, 32'(hit_idx), 32'(ei));
    check({tag, " out"}, out_addr, eo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // {addr, space, qual, hit, idx, out}
  localparam int NV = 15;
  localparam logic [74:0] VEC [NV] = '{
    {32'h1000_0000, 3'd2, 4'h4, 1'b1, 3'd0, 32'h3000_0000},  // R6 start inclusive
    {32'h1000_2FFF, 3'd2, 4'h4, 1'b1, 3'd0, 32'h3000_2FFF},  // R8 W0 over W2
    {32'h1000_3000, 3'd2, 4'h4, 1'b1, 3'd2, 32'h1001_3000},  // R6 W0 bound exclusive
    {32'h1001_0000, 3'd2, 4'h4, 1'b0, 3'd0, 32'h1001_0000},  // R7 miss passthrough
    {32'h1000_0000, 3'd2, 4'h5, 1'b0, 3'd0, 32'h1000_0000},  // R5 qualifier mismatch
    {32'h1000_0000, 3'd1, 4'h4, 1'b0, 3'd0, 32'h1000_0000},  // R4 space mismatch
    {32'h0050_0010, 3'd1, 4'hA, 1'b1, 3'd1, 32'h0000_0010},  // R7 wraps
    {32'h005F_FFFF, 3'd1, 4'hA, 1'b1, 3'd1, 32'h000F_FFFF},  // R7 wraps
    {32'h0060_0000, 3'd1, 4'hA, 1'b0, 3'd0, 32'h0060_0000},  // R6 64K bound
    {32'h3000_0000, 3'd3, 4'h4, 1'b0, 3'd0, 32'h3000_0000},  // R4 code 3
    {32'h0000_1FFF, 3'd0, 4'h1, 1'b1, 3'd4, 32'h4000_1FFF},  // R6 4K window 4
    {32'h0000_2000, 3'd0, 4'h1, 1'b0, 3'd0, 32'h0000_2000},  // R6
    {32'h0000_0FFF, 3'd0, 4'h1, 1'b0, 3'd0, 32'h0000_0FFF},  // R6 below start
    {32'h5000_0000, 3'd2, 4'h4, 1'b0, 3'd0, 32'h5000_0000},  // R3 disabled
    {32'h004F_FFFF, 3'd1, 4'hA, 1'b0, 3'd0, 32'h004F_FFFF}   // R6 below start
  };

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd("R1 ctrl0", 0, 32'h0);
    rd("R1 start1", 6, 32'h0);
    look("R1 lookup", 32'h0, 3'd0, 4'h0, 1'b0, 3'd0, 32'h0);

    // programming
    wr(0, 32'h8042_0000); wr(1, 32'h1000_0ABC); wr(2, 32'h1000_3000); wr(3, 32'h2000_0000);
    wr(5, 32'h80A1_0000); wr(6, 32'h0050_1234); wr(7, 32'h0060_0000); wr(8, 32'hFFB0_0000);
    wr(10, 32'h8042_0000); wr(11, 32'h1000_0000); wr(12, 32'h1001_0000); wr(13, 32'h0001_0000);
    wr(15, 32'h8043_0000); wr(16, 32'h3000_0000); wr(17, 32'h3001_0000);
    wr(20, 32'h8010_0000); wr(21, 32'h0000_1000); wr(22, 32'h0000_2000); wr(23, 32'h4000_0000);
    wr(25, 32'h0042_0000); wr(26, 32'h5000_0000); wr(27, 32'h5001_0000); wr(28, 32'h0);
    wr(30, 32'h7FFF_FFFF);
    wr(4, 32'hFFFF_FFFF); wr(40, 32'hFFFF_FFFF);

    // R2 / R6 readback
    rd("R6 W0 start 4K mask", 1, 32'h1000_0000);
    rd("R6 W1 start 64K mask", 6, 32'h0050_0000);
    rd("R2 ctrl keep bits", 30, 32'h00F7_0000);
    rd("R2 word4 ignored", 4, 32'h0);
    rd("R2 index 40 ignored", 40, 32'h0);
    rd("R2 W4 ctrl", 20, 32'h8010_0000);

    // R9 reduced revision
    @(negedge clk); reg_addr = 6'd20;
    #1 check("R9 W4 absent read", rd1, 32'h0);
    in_addr = 32'h0000_1FFF; in_space = 3'd0; in_qual = 4'h1;
    #1 check("R9 W4 absent hit", 32'(hit1), 32'h0);
    in_addr = 32'h1000_0000; in_space = 3'd2; in_qual = 4'h4;
    #1 check("R9 W0 present hit", 32'(hit1), 32'h1);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      look($sformatf("vec%0d", i), v[74:43], v[42:40], v[39:36], v[35], v[34:32], v[31:0]);
    end

    // R10: write takes effect only at the sampling edge
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'd25; reg_wdata = 32'h8042_0000;
    in_addr = 32'h5000_0000; in_space = 3'd2; in_qual = 4'h4;
    #1 check("R10 before edge", 32'(hit), 32'h0);
    @(negedge clk);
    reg_we = 1'b0;
    #1 check("R10 after edge hit", 32'(hit), 32'h1);
    check("R10 after edge idx", 32'(hit_idx), 32'h5);
    check("R10 after edge out", out_addr, 32'h5000_0000);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R1 after reset", 32'h1000_0000, 3'd2, 4'h4, 1'b0, 3'd0, 32'h1000_0000);
    rd("R1 ctrl0 cleared", 0, 32'h0);

    finish_run();
  end
endmodule